// File: doc/BRIEF.md
# Boot Address and Fetch Release Controller

This block sits between a simple peripheral bus slave port and the boot inputs of a processor core. Software or a debugger writes a boot address and a fetch-enable bit through the bus. The block drives the core's first program counter and its fetch-enable pin from these registers.

A sticky flag records the first cycle out of reset in which fetch is enabled. From that point the core-facing enable stays high and the core-facing boot address stays frozen until the next reset, whatever the registers hold afterwards. The registers share the core's reset, so a new reset returns everything to the default values. With the default settings, fetch is released on the first clock after reset.

The bus side uses the usual select/enable handshake. There is no back-pressure: every access phase finishes in one cycle and the error response is never raised. No data stream passes through the block, so it has no valid/ready interface.

Top module: `bootfetch_ctrl`

## Requirements
- R1: After reset, the register at offset 0x0 (boot address) reads 0x1A000080. The register at offset 0x4 (fetch enable, bit 0) reads the `FETCH_RST` parameter value. The status register at offset 0x8 reads 0. `core_boot_addr` shows 0x1A000080.
- R2: Bit 0 of the boot-address register always reads 0 and ignores written data. `core_boot_addr[0]` is always 0.
- R3: While the fetch-enable register is 0 and fetch has not been released, `core_fetch_en` is 0 and the release flag stays clear.
- R4: A write of 1 to offset 0x4 drives `core_fetch_en` high from the clock edge that ends the write. Status bit 0 at offset 0x8 reads 1 from the following cycle.
- R5: After release, writing 0 to offset 0x4 changes the readback to 0 but leaves `core_fetch_en` at 1.
- R6: Before release, `core_boot_addr` follows the boot-address register. After release it holds the value captured at release, while bus writes still update the readback at offset 0x0.
- R7: Reads from any offset other than 0x0, 0x4 and 0x8 return 0. Writes to those offsets change no register.
- R8: During every access phase (select and enable both high), `pready` is 1. `pslverr` is always 0.
- R9: The status register at offset 0x8 is read-only. Writes to it have no effect.
- R10: A reset clears the release flag and restores the default register values, including after a release has taken place.
- R11: With the default `FETCH_RST` of 1, `core_fetch_en` is high and the release flag is set one clock after reset is removed, with `core_boot_addr` at 0x1A000080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, shared with the core |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access-phase enable |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the access phase |
| pready | output | 1 | Access complete, high in every access phase |
| pslverr | output | 1 | Error response, tied low |
| core_boot_addr | output | DATA_W | First program counter presented to the core |
| core_fetch_en | output | 1 | Fetch enable presented to the core |

## Verification
The bench builds two copies of the block. The main copy uses `FETCH_RST` set to 0. This holds the core in the pre-release window after reset, so boot-address changes, unmapped and read-only writes, the explicit release and the frozen address after release can all be observed. A second copy keeps every parameter at its default and has no bus traffic. It shows the default behaviour of releasing fetch immediately after reset with the default address. Both copies use the default 12-bit address and 32-bit data widths.

// File: rtl/bootfetch_pkg.sv
package bootfetch_pkg;

  typedef enum logic [1:0] {
    SEL_BOOT  = 2'd0,
    SEL_FETCH = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Word indices (byte offset / 4) of the mapped registers
  localparam int unsigned WIDX_BOOT  = 0;
  localparam int unsigned WIDX_FETCH = 1;
  localparam int unsigned WIDX_STAT  = 2;

  function automatic reg_sel_e decode_word(input int unsigned widx);
    reg_sel_e s;
    if (widx == WIDX_BOOT)       s = SEL_BOOT;
    else if (widx == WIDX_FETCH) s = SEL_FETCH;
    else if (widx == WIDX_STAT)  s = SEL_STAT;
    else                         s = SEL_NONE;
    return s;
  endfunction

endpackage

// File: rtl/bf_regs.sv
module bf_regs
  import bootfetch_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 12,
  parameter int unsigned     DATA_W    = 32,
  parameter logic [DATA_W-1:0] BOOT_RST = 32'h1A00_0080,
  parameter logic            FETCH_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic              started,
  output logic [DATA_W-1:0] prdata,
  output logic [DATA_W-1:0] boot_q,
  output logic              fetch_q
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] BOOT_RST_AL = {BOOT_RST[DATA_W-1:1], 1'b0};

  logic [WORD_W-1:0] widx;
  reg_sel_e          sel;
  logic              wr_en;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_lsb;

  assign widx       = paddr[ADDR_W-1:2];
  assign unused_lsb = ^paddr[1:0];
  assign sel        = decode_word(int'(widx));
  assign wr_en      = psel & penable & pwrite;

  // Boot address: bit 0 is held at zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= BOOT_RST_AL;
    end else if (wr_en && sel == SEL_BOOT) begin
      boot_q <= {pwdata[DATA_W-1:1], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= FETCH_RST;
    end else if (wr_en && sel == SEL_FETCH) begin
      fetch_q <= pwdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_BOOT:  rd_mux = boot_q;
      SEL_FETCH: rd_mux[0] = fetch_q;
      SEL_STAT:  rd_mux[0] = started;
      default:   rd_mux = '0;
    endcase
  end

  assign prdata = psel ? rd_mux : '0;

endmodule

// File: rtl/bf_release.sv
module bf_release #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_q,
  input  logic [DATA_W-1:0] boot_q,
  output logic              started_q,
  output logic              core_fetch_en,
  output logic [DATA_W-1:0] core_boot_addr
);

  logic [DATA_W-1:0] held_q;
  logic              release_now;

  assign release_now = fetch_q & ~started_q;

  // Sticky: only a reset clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else if (release_now) started_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else if (release_now) held_q <= boot_q;
  end

  assign core_fetch_en  = started_q | fetch_q;
  assign core_boot_addr = started_q ? held_q : boot_q;

endmodule

// File: rtl/bootfetch_ctrl.sv
module bootfetch_ctrl #(
  parameter int unsigned       ADDR_W    = 12,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] BOOT_RST  = 32'h1A00_0080,
  parameter logic              FETCH_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [DATA_W-1:0] core_boot_addr,
  output logic              core_fetch_en
);

  logic [DATA_W-1:0] boot_q;
  logic              fetch_q;
  logic              fetch_started;

  bf_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BOOT_RST (BOOT_RST),
    .FETCH_RST(FETCH_RST)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .pwdata (pwdata),
    .started(fetch_started),
    .prdata (prdata),
    .boot_q (boot_q),
    .fetch_q(fetch_q)
  );

  bf_release #(
    .DATA_W(DATA_W)
  ) u_rel (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_q       (fetch_q),
    .boot_q        (boot_q),
    .started_q     (fetch_started),
    .core_fetch_en (core_fetch_en),
    .core_boot_addr(core_boot_addr)
  );

  // No wait states, no error responses
  assign pready  = psel & penable;
  assign pslverr = 1'b0;

endmodule

// File: rtl/bootfetch_ctrl_chk.sv
module bootfetch_ctrl_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_fetch_en,
  input logic [DATA_W-1:0] core_boot_addr,
  input logic              started
);

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_boot_addr[0] == 1'b0);

  p_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_fetch_en && !started) |=> !started);

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_fetch_en && !started) |=> started);

  p_keep_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> core_fetch_en);

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(started)) |-> $stable(core_boot_addr));

endmodule

bind bootfetch_ctrl bootfetch_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_fetch_en (core_fetch_en),
  .core_boot_addr(core_boot_addr),
  .started       (fetch_started)
);

// File: tb/sim_bootfetch_ctrl.sv
`timescale 1ns/1ps
module sim_bootfetch_ctrl;

  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata, boot0, boot1, prdata1;
  logic          pready, pslverr, fen0, fen1, pready1, pslverr1;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [DW-1:0] val; string req; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  bootfetch_ctrl #(.ADDR_W(AW), .DATA_W(DW), .FETCH_RST(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .core_boot_addr(boot0), .core_fetch_en(fen0));

  // Default parameters, idle bus
  bootfetch_ctrl u1 (
    .clk(clk), .rst_n(rst_n), .psel(1'b0), .penable(1'b0), .pwrite(1'b0),
    .paddr(12'h0), .pwdata(32'h0), .prdata(prdata1), .pready(pready1),
    .pslverr(pslverr1), .core_boot_addr(boot1), .core_fetch_en(fen1));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    exp_t it;
    it.val = e; it.req = req;
    exp_q.push_back(it);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  // Monitor: compares read data in each access phase, and the handshake (R8)
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (psel && penable) begin
        check("R8 pready", {31'b0, pready}, 32'h1);
        check("R8 pslverr", {31'b0, pslverr}, 32'h0);
        if (!pwrite) begin
          if (exp_q.size() == 0) begin
            check("scoreboard underflow", 32'h1, 32'h0);
          end else begin
            exp_t it;
            it = exp_q.pop_front();
            check(it.req, prdata, it.val);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 core_boot_addr in reset", boot0, 32'h1A00_0080);
    check("R3 fetch low in reset", {31'b0, fen0}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    // R11: default instance released one edge after reset
    check("R11 default fetch_en", {31'b0, fen1}, 32'h1);
    check("R11 default boot addr", boot1, 32'h1A00_0080);
    #1;
    bus_read(12'h000, 32'h1A00_0080, "R1 boot reg reset");
    bus_read(12'h004, 32'h0, "R1 fetch reg reset");
    bus_read(12'h008, 32'h0, "R1 status reset");
    repeat (4) @(negedge clk);
    check("R3 fetch held low", {31'b0, fen0}, 32'h0);
    bus_read(12'h008, 32'h0, "R3 not released");

    bus_write(12'h000, 32'h2000_0003);
    bus_read(12'h000, 32'h2000_0002, "R2 bit0 reads zero");
    #1;
    check("R6 output tracks before release", boot0, 32'h2000_0002);
    check("R2 output bit0", {31'b0, boot0[0]}, 32'h0);

    bus_write(12'h00C, 32'hFFFF_FFFF);
    bus_write(12'h100, 32'hFFFF_FFFF);
    bus_read(12'h00C, 32'h0, "R7 unmapped reads zero");
    bus_read(12'h000, 32'h2000_0002, "R7 boot untouched");
    bus_read(12'h004, 32'h0, "R7 fetch untouched");

    bus_write(12'h008, 32'h1);
    bus_read(12'h008, 32'h0, "R9 status read-only");
    check("R9 no release", {31'b0, fen0}, 32'h0);

    bus_write(12'h004, 32'h1);
    #1;
    check("R4 fetch_en high after write", {31'b0, fen0}, 32'h1);
    bus_read(12'h008, 32'h1, "R4 status set");

    bus_write(12'h000, 32'h3000_0000);
    bus_read(12'h000, 32'h3000_0000, "R6 readback updates");
    #1;
    check("R6 output frozen", boot0, 32'h2000_0002);

    bus_write(12'h004, 32'h0);
    bus_read(12'h004, 32'h0, "R5 readback cleared");
    #1;
    check("R5 fetch_en stays high", {31'b0, fen0}, 32'h1);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(12'h008, 32'h0, "R10 status cleared");
    bus_read(12'h000, 32'h1A00_0080, "R10 boot restored");
    #1;
    check("R10 fetch_en low", {31'b0, fen0}, 32'h0);
    check("R10 boot output", boot0, 32'h1A00_0080);
    check("R11 default re-released", {31'b0, fen1}, 32'h1);

    repeat (2) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule